// File: doc/BRIEF.md
# Fixed Off-Time Peak Current Chopper

This block regulates winding current in a three-phase bridge by peak detection with a fixed off-time. A digitized sense-comparator trip, sampled while the high-side source is conducting and no blanking window is open, clears a source-enable latch. The latch stays cleared for a fixed number of clock cycles and then sets again. On every release a blanking window opens in which further trips are thrown away, so that the recovery spike at switch-on cannot cut the new on-phase short.

An external chop input gives the system its own PWM. A low level on it lets the latch drive the source, and a high level forces the source off into slow decay. The blanking window restarts whenever the filtered chop input turns the bridge back on and whenever the filtered direction input changes. When the chop input stays high for a long time, a standby request is raised, and it drops as soon as the input is low again. Both the chop input and the direction input pass through glitch filters of their own before any of this logic sees them. All durations are parameters counted in clock cycles.

Top module: `chop_regulator`

## Requirements
- R1: While reset is asserted and right after it, the source-enable latch is set, no blanking window is open, the filtered chop level is high, the filtered direction is low, and both `src_en_o` and `standby_o` are low.
- R2: `src_en_o` is high exactly when the source-enable latch is set and the filtered chop level is low.
- R3: A clock edge at which `trip_i` is high, `src_en_o` is high and no blanking window is open clears the latch, so `src_en_o` is low after that edge.
- R4: After a trip is taken, the latch stays clear for exactly OFF_CYC clock edges and sets again at the OFF_CYC-th edge. Trips arriving in that time have no effect.
- R5: The edge that sets the latch again opens a blanking window covering the next BLANK_CYC edges. A trip inside that window is dropped and is not taken later.
- R6: The edge at which the filtered chop level falls from high to low opens a fresh blanking window of BLANK_CYC edges.
- R7: The edge at which the filtered direction changes opens a fresh blanking window of BLANK_CYC edges, and this holds during the off-time too.
- R8: The filtered chop level takes a new raw value only after that value has been sampled on EN_FILT consecutive edges. A shorter pulse changes nothing.
- R9: The filtered direction takes a new raw value only after DIR_FILT consecutive edges. A shorter direction pulse opens no blanking window.
- R10: `standby_o` rises at the STBY_CYC-th consecutive edge with the filtered chop level high, counting from the edge at which that level became high (from the first edge after reset when it starts high). It falls at the edge at which the filtered level goes low.
- R11: A trip while the filtered chop level is high never clears the latch, so the source is on at once when chop goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Digitized sense-comparator output, high when the current is at or above its peak |
| chop_i | input | 1 | External chop input: low drives the bridge, high chops the source |
| dir_i | input | 1 | Rotation direction input, raw |
| src_en_o | output | 1 | Source enable to the gate sequencer |
| standby_o | output | 1 | Standby request after a long chop-high interval |

## Verification
Long runs with the trip held high show the regulation cycle on its own: an exact off-time, then a blanking window, then an immediate new trip. These runs tell an off-by-one in the off-time counter apart from one in the blanking counter. Trips held through a chop-low transition and through a direction change show which event reopened blanking. Short chop and direction pulses one cycle below their filter lengths, set beside pulses of exactly the filter length, show that the filter thresholds are right. A chop-high stretch longer than the standby limit, plus random mixes of short chops, trip bursts and direction flips, checks the standby counter and its restart together with everything above.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // A trip is taken only while the source really conducts and blanking is idle.
  function automatic logic take_trip(input logic trip, input logic latch_set,
                                     input logic chop_high, input logic blank_busy);
    return trip & latch_set & ~chop_high & ~blank_busy;
  endfunction

  // Any of these events loads the blanking counter to its full length.
  function automatic logic blank_reload(input logic chop_on, input logic dir_chg,
                                        input logic release_now);
    return chop_on | dir_chg | release_now;
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/chop_deglitch.sv
module chop_deglitch #(
  parameter int   N_STABLE = 4,
  parameter logic RST_LVL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic commit_o
);
  localparam int CW = chop_pkg::cnt_bits(N_STABLE - 1);
  localparam logic [CW-1:0] LAST = CW'(N_STABLE - 1);

  logic [CW-1:0] run_q;

  assign commit_o = (raw_i != level_o) && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= RST_LVL;
      run_q   <= '0;
    end else if (raw_i == level_o) begin
      run_q <= '0;
    end else if (commit_o) begin
      level_o <= raw_i;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/chop_offtime_core.sv
module chop_offtime_core #(
  parameter int OFF_CYC   = 25,
  parameter int BLANK_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_take_i,
  input  logic chop_on_i,
  input  logic dir_chg_i,
  output logic src_latch_o,
  output logic blanking_o
);
  localparam int OW = chop_pkg::cnt_bits(OFF_CYC);
  localparam int BW = chop_pkg::cnt_bits(BLANK_CYC);
  localparam logic [OW-1:0] OFF_LOAD   = OW'(OFF_CYC);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

  logic [OW-1:0] off_q;
  logic [BW-1:0] blank_q;
  logic          release_now;

  assign release_now = ~src_latch_o && (off_q == OW'(1));
  assign blanking_o  = (blank_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_latch_o <= 1'b1;
      off_q       <= '0;
    end else if (trip_take_i) begin
      src_latch_o <= 1'b0;
      off_q       <= OFF_LOAD;
    end else if (release_now) begin
      src_latch_o <= 1'b1;
      off_q       <= '0;
    end else if (!src_latch_o) begin
      off_q <= off_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
    end else if (chop_pkg::blank_reload(chop_on_i, dir_chg_i, release_now)) begin
      blank_q <= BLANK_LOAD;
    end else if (blank_q != '0) begin
      blank_q <= blank_q - 1'b1;
    end
  end
endmodule

// File: rtl/chop_standby_det.sv
module chop_standby_det #(
  parameter int STBY_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic high_nxt_i,
  output logic standby_o
);
  localparam int CW = chop_pkg::cnt_bits(STBY_CYC);
  localparam logic [CW-1:0] LAST = CW'(STBY_CYC - 1);

  logic [CW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      standby_o <= 1'b0;
    end else if (!high_nxt_i) begin
      len_q     <= '0;
      standby_o <= 1'b0;
    end else if (len_q == LAST) begin
      standby_o <= 1'b1;
    end else begin
      len_q <= len_q + 1'b1;
    end
  end
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator #(
  parameter int EN_FILT   = 4,
  parameter int DIR_FILT  = 8,
  parameter int OFF_CYC   = 25,
  parameter int BLANK_CYC = 6,
  parameter int STBY_CYC  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic chop_i,
  input  logic dir_i,
  output logic src_en_o,
  output logic standby_o
);
  logic chop_lvl, chop_commit, chop_on, chop_nxt;
  logic dir_lvl, dir_commit;
  logic src_latch, blanking, trip_take;

  chop_deglitch #(.N_STABLE(EN_FILT), .RST_LVL(1'b1)) u_chop_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(chop_i),
    .level_o(chop_lvl), .commit_o(chop_commit));

  chop_deglitch #(.N_STABLE(DIR_FILT), .RST_LVL(1'b0)) u_dir_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(dir_i),
    .level_o(dir_lvl), .commit_o(dir_commit));

  assign chop_on   = chop_commit & chop_lvl;
  assign chop_nxt  = chop_commit ? ~chop_lvl : chop_lvl;
  assign trip_take = chop_pkg::take_trip(trip_i, src_latch, chop_lvl, blanking);

  chop_offtime_core #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .trip_take_i(trip_take),
    .chop_on_i(chop_on), .dir_chg_i(dir_commit),
    .src_latch_o(src_latch), .blanking_o(blanking));

  chop_standby_det #(.STBY_CYC(STBY_CYC)) u_stby (
    .clk(clk), .rst_n(rst_n), .high_nxt_i(chop_nxt), .standby_o(standby_o));

  assign src_en_o = src_latch & ~chop_lvl;
endmodule

// File: rtl/chop_regulator_sva.sv
module chop_regulator_sva (
  input logic clk,
  input logic rst_n,
  input logic trip_i,
  input logic src_en_o,
  input logic standby_o,
  input logic chop_lvl,
  input logic dir_lvl,
  input logic src_latch,
  input logic blanking
);
  AST_TRIP_CUTS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en_o && trip_i && !blanking) |=> !src_en_o); // R3
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_latch) |=> !src_latch); // R4
  AST_BLANK_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_latch) |-> blanking); // R5
  AST_BLANK_DROPS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && trip_i && src_latch) |=> src_latch); // R5
  AST_CHOP_ON_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chop_lvl) |-> blanking); // R6
  AST_DIR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_lvl != $past(dir_lvl)) |-> blanking); // R7
  AST_STBY_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> chop_lvl); // R10
  AST_CHOP_HIGH_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_lvl && src_latch) |=> src_latch); // R11
endmodule

bind chop_regulator chop_regulator_sva u_sva (
  .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .src_en_o(src_en_o),
  .standby_o(standby_o), .chop_lvl(chop_lvl), .dir_lvl(dir_lvl),
  .src_latch(src_latch), .blanking(blanking));

// File: tb/tb_chop_regulator.sv
module tb_chop_regulator;
  localparam int EN_FILT = 4, DIR_FILT = 8, OFF_CYC = 25, BLANK_CYC = 6, STBY_CYC = 200;

  logic clk = 1'b0, rst_n = 1'b0, trip_i = 1'b0, chop_i = 1'b1, dir_i = 1'b0;
  logic src_en_o, standby_o;
  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state, kept as edge timestamps
  int n = 0;
  bit m_chop = 1'b1, m_dir = 1'b0, m_latch = 1'b1, m_stby = 1'b0;
  int chop_run = 0, dir_run = 0, off_end = 0, blank_last = 0, high_since = 1;

  always #2 clk = ~clk;

  chop_regulator dut (.clk(clk), .rst_n(rst_n), .trip_i(trip_i), .chop_i(chop_i),
                      .dir_i(dir_i), .src_en_o(src_en_o), .standby_o(standby_o));

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, n, act, exp);
    end
  endtask

  function automatic bit filt_step(input bit lvl, input bit raw, inout int run, input int need);
    if (raw == lvl) begin run = 0; return lvl; end
    run++;
    if (run >= need) begin run = 0; return raw; end
    return lvl;
  endfunction

  // One rising edge of the reference, then compare outputs at the falling edge.
  task automatic step();
    bit chop_b, latch_b, new_chop, new_dir, busy;
    @(posedge clk);
    n++;
    chop_b  = m_chop;
    latch_b = m_latch;
    busy    = (n <= blank_last);
    new_chop = filt_step(m_chop, chop_i, chop_run, EN_FILT);
    new_dir  = filt_step(m_dir, dir_i, dir_run, DIR_FILT);
    if (trip_i && latch_b && !chop_b && !busy) begin
      m_latch = 1'b0;
      off_end = n + OFF_CYC;
    end else if (!latch_b && n == off_end) begin
      m_latch = 1'b1;
      blank_last = n + BLANK_CYC;
    end
    if ((chop_b && !new_chop) || (new_dir != m_dir)) blank_last = n + BLANK_CYC;
    if (new_chop) begin
      if (!chop_b) high_since = n;
      m_stby = (n - high_since + 1 >= STBY_CYC);
    end else m_stby = 1'b0;
    m_chop = new_chop;
    m_dir  = new_dir;
    @(negedge clk);
    check(tag, src_en_o, m_latch && !m_chop, "src_en_o");
    check(tag, standby_o, m_stby, "standby_o");
  endtask

  task automatic run(input int cyc);
    for (int i = 0; i < cyc; i++) step();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired at edge %0d: actual hung expected done", n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    repeat (3) @(negedge clk);
    check("R1", src_en_o, 1'b0, "src_en_o in reset");
    check("R1", standby_o, 1'b0, "standby_o in reset");
    rst_n = 1'b1;
    // R10: chop held high from reset until standby, then released
    tag = "R10"; run(STBY_CYC + 5);
    // R8: a chop-low pulse one cycle short of the filter is rejected
    tag = "R8"; chop_i = 1'b0; run(EN_FILT - 1); chop_i = 1'b1; run(6);
    chop_i = 1'b0; run(EN_FILT);
    // R6 and R5: trip held from the chop turn-on, through blanking and off-times
    tag = "R6"; trip_i = 1'b1; run(BLANK_CYC + 3);
    tag = "R4"; run(OFF_CYC + BLANK_CYC + 4);
    tag = "R5"; run(2 * (OFF_CYC + BLANK_CYC + 1));
    trip_i = 1'b0; run(OFF_CYC + 2);
    // R9 and R7: short direction pulse, then a real change with trip held
    tag = "R9"; dir_i = 1'b1; run(DIR_FILT - 1); dir_i = 1'b0; trip_i = 1'b1; run(4);
    trip_i = 1'b0; run(OFF_CYC + BLANK_CYC + 2);
    tag = "R7"; dir_i = 1'b1; run(DIR_FILT - 1); trip_i = 1'b1; run(BLANK_CYC + 4);
    dir_i = 1'b0; run(DIR_FILT + 3); trip_i = 1'b0; run(OFF_CYC + 4);
    // R11: trips while chop is high, then chop low gives the source at once
    tag = "R11"; chop_i = 1'b1; run(EN_FILT + 1); trip_i = 1'b1; run(10);
    trip_i = 1'b0; chop_i = 1'b0; run(EN_FILT + 2);
    // R2 and R3: random chop, trip and direction patterns
    tag = "R3";
    for (int seg = 0; seg < 160; seg++) begin
      int len;
      tag = (seg % 2) ? "R2" : "R3";
      chop_i = ($urandom % 3 == 0);
      len = ($urandom % 25 == 0) ? STBY_CYC + 10 : 1 + $urandom % 30;
      for (int c = 0; c < len; c++) begin
        trip_i = ($urandom % 4 == 0);
        if ($urandom % 90 == 0) dir_i = ~dir_i;
        step();
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule